// File: doc/BRIEF.md
# GPIO Set/Clear Output Register

This block is a configuration-space register that controls a small general-purpose output bus. Software never writes the pin levels directly. One byte of a configuration dword carries two nibbles: a write-1-to-clear nibble that pulls chosen pins low and a write-1-to-set nibble that pulls chosen pins high. A zero in either nibble leaves the pin alone, so software can change one pin without a read-modify-write and without disturbing the others.

The block decodes configuration writes by dword address and active-low byte enables. It keeps one output data bit per pin. The new level appears on the clock after the write completes. A separate direction vector, owned elsewhere, marks each pin as bidirectional or input-only. The block drives a pin's output enable only while the pin is bidirectional. The stored data bit is kept while the pin is undriven, so it takes effect when the pin is later switched to bidirectional. A configuration read returns the byte last written to each nibble. The pad buffers and the direction register sit outside the block.

Top module: `gpio_setclr_reg`

## Requirements
- R1: A write changes state only when cfg_addr[7:2] equals the dword address 64h (byte address bits [1:0] are ignored) and the active-low enable cfg_be_n[1] is 0; any other address, or cfg_be_n[1] equal to 1, leaves the outputs and the readback unchanged.
- R2: In a selected write, a 1 in data bit 8+i (bits 11:8 form the clear nibble) makes gpio_out[i] equal to 0.
- R3: In a selected write, a 1 in data bit 12+i (bits 15:12 form the set nibble) makes gpio_out[i] equal to 1.
- R4: A selected write with 0 in both bit 8+i and bit 12+i leaves gpio_out[i] unchanged.
- R5: gpio_out keeps its old value during the cycle in which cfg_wr is high and shows the new value from the following cycle on.
- R6: gpio_oe[i] equals dir[i] (1 = bidirectional, driven; 0 = input-only, never driven), whatever is written.
- R7: gpio_out[i] keeps its written value while dir[i] is 0, and that value is driven as soon as dir[i] becomes 1.
- R8: While cfg_rd is high and cfg_addr selects dword 64h, cfg_rdata[11:8] returns the clear nibble of the last selected write and cfg_rdata[15:12] returns its set nibble, and every other bit is 0. cfg_rdata is 0 otherwise.
- R9: Reset (rst_n low) clears gpio_out and both stored nibbles to 0.
- R10: When one selected write has a 1 in both bit 8+i and bit 12+i, the set wins and gpio_out[i] becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle strobe marking a completed configuration write |
| cfg_rd | input | 1 | Configuration read in progress |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be_n | input | 4 | Active-low byte enables of the dword |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| dir | input | 4 | Per-pin direction, 1 = bidirectional |
| gpio_out | output | 4 | Output data per pin |
| gpio_oe | output | 4 | Output enable per pin |

## Verification
The hardest case to reach is a pin whose data changes while it is input-only and is then released to drive. This needs the direction vector dropped first, then set and clear writes aimed at the undriven pin, then the direction raised again. The bench follows that order and checks the retained level on gpio_out with gpio_oe still low, and again once it goes high. Collisions also need a deliberate stimulus: writes that carry 1 in both nibbles for the same pin, and writes that hit the right address with the byte lane disabled while the other lanes carry all ones.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

   // Byte width of one configuration lane
   localparam int unsigned LANE_BITS = 8;

   // Pull one byte lane out of a configuration data word
   function automatic logic [LANE_BITS-1:0] lane_of(input logic [31:0] word,
                                                    input int unsigned lane);
      return word[lane*LANE_BITS +: LANE_BITS];
   endfunction

   // Per-pin command decoded from the two nibbles
   typedef enum logic [1:0] {
      PIN_HOLD  = 2'b00,
      PIN_CLEAR = 2'b01,
      PIN_SET   = 2'b10
   } pin_cmd_e;

endpackage

// File: rtl/gsc_cfg_decode.sv
module gsc_cfg_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned BE_W       = 4,
   parameter int unsigned DWORD_ADDR = 'h64,
   parameter int unsigned LANE       = 1
) (
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BE_W-1:0]   cfg_be_n,
   output logic              wr_hit,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] MATCH = DWORD_ADDR[ADDR_W-1:0];

   initial begin
      if (ADDR_W < 3) $error("gsc_cfg_decode: ADDR_W too small");
      if (LANE >= BE_W) $error("gsc_cfg_decode: LANE outside byte enables");
      if (MATCH[1:0] != 2'b00) $error("gsc_cfg_decode: DWORD_ADDR not dword aligned");
   end

   logic addr_match;
   assign addr_match = (cfg_addr[ADDR_W-1:2] == MATCH[ADDR_W-1:2]);
   assign wr_hit     = cfg_wr & addr_match & ~cfg_be_n[LANE];
   assign rd_hit     = cfg_rd & addr_match;
endmodule

// File: rtl/gsc_pin_cell.sv
module gsc_pin_cell
   import gsc_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic set_bit,
   input  logic clr_bit,
   output logic pin_q
);
   pin_cmd_e cmd;

   generate
      if (SET_WINS) begin : g_set_priority
         always_comb begin
            if (!wr_hit)      cmd = PIN_HOLD;
            else if (set_bit) cmd = PIN_SET;
            else if (clr_bit) cmd = PIN_CLEAR;
            else              cmd = PIN_HOLD;
         end
      end else begin : g_clr_priority
         always_comb begin
            if (!wr_hit)      cmd = PIN_HOLD;
            else if (clr_bit) cmd = PIN_CLEAR;
            else if (set_bit) cmd = PIN_SET;
            else              cmd = PIN_HOLD;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else begin
         case (cmd)
            PIN_SET:   pin_q <= 1'b1;
            PIN_CLEAR: pin_q <= 1'b0;
            default:   pin_q <= pin_q;
         endcase
      end
   end

   // R3 set drives the pin high on the next cycle
   p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && set_bit && (SET_WINS || !clr_bit)) |=> pin_q);
   // R2 clear drives the pin low on the next cycle
   p_clr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && clr_bit && (!SET_WINS || !set_bit)) |=> !pin_q);
   // R4 zeros in both nibbles keep the pin
   p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !set_bit && !clr_bit) |=> $stable(pin_q));
   // R1 no selected write, no change
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(pin_q));
endmodule

// File: rtl/gsc_field_shadow.sv
module gsc_field_shadow #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   initial begin
      if (W == 0) $error("gsc_field_shadow: W must be nonzero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_hit) q <= wdata;
   end

   // R8 readback holds the byte of the last selected write
   p_shadow_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (q == $past(wdata)));
   p_shadow_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(q));
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
   import gsc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NPINS      = 4,
   parameter int unsigned DWORD_ADDR = 'h64,
   parameter int unsigned LANE       = 1,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [3:0]        cfg_be_n,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [NPINS-1:0]  dir,
   output logic [NPINS-1:0]  gpio_out,
   output logic [NPINS-1:0]  gpio_oe
);
   localparam int unsigned BE_W    = DATA_W / LANE_BITS;
   localparam int unsigned LANE_LO = LANE * LANE_BITS;
   localparam int unsigned CLR_LSB = LANE_LO;
   localparam int unsigned SET_LSB = LANE_LO + NPINS;

   initial begin
      if (DATA_W != 32) $error("gpio_setclr_reg: DATA_W must be 32");
      if (2 * NPINS > LANE_BITS) $error("gpio_setclr_reg: both nibbles must fit in one lane");
      if (LANE >= BE_W) $error("gpio_setclr_reg: LANE outside the dword");
   end

   logic                 wr_hit;
   logic                 rd_hit;
   logic [LANE_BITS-1:0] wr_byte;
   logic [LANE_BITS-1:0] shadow_q;
   logic [NPINS-1:0]     set_nib;
   logic [NPINS-1:0]     clr_nib;

   gsc_cfg_decode #(
      .ADDR_W    (ADDR_W),
      .BE_W      (4),
      .DWORD_ADDR(DWORD_ADDR),
      .LANE      (LANE)
   ) u_decode (
      .cfg_wr  (cfg_wr),
      .cfg_rd  (cfg_rd),
      .cfg_addr(cfg_addr),
      .cfg_be_n(cfg_be_n),
      .wr_hit  (wr_hit),
      .rd_hit  (rd_hit)
   );

   assign wr_byte = cfg_wdata[LANE_LO +: LANE_BITS];
   assign clr_nib = cfg_wdata[CLR_LSB +: NPINS];
   assign set_nib = cfg_wdata[SET_LSB +: NPINS];

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         gsc_pin_cell #(.SET_WINS(SET_WINS)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .set_bit(set_nib[i]),
            .clr_bit(clr_nib[i]),
            .pin_q  (gpio_out[i])
         );
      end
   endgenerate

   gsc_field_shadow #(.W(LANE_BITS)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(wr_hit),
      .wdata (wr_byte),
      .q     (shadow_q)
   );

   // Pins marked input-only are never driven
   assign gpio_oe = dir;

   always_comb begin
      cfg_rdata = '0;
      if (rd_hit) cfg_rdata[LANE_LO +: LANE_BITS] = shadow_q;
   end

   // R5 outputs move only on the clock after a selected write
   p_out_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_hit) |-> $stable(gpio_out));
   // R8 nothing on the read bus without a selected read
   p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (cfg_rdata == '0));
   // R7 data survives a direction change
   p_dir_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && (dir != $past(dir))) |=> $stable(gpio_out));
endmodule

// File: tb/gpio_setclr_reg_bench.sv
`timescale 1ns/100ps
module gpio_setclr_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [3:0]  cfg_be_n = 4'hF;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [3:0]  dir = 4'h0;
   logic [3:0]  gpio_out;
   logic [3:0]  gpio_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0]  out;
      logic [3:0]  oe;
      logic [31:0] rd;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [3:0] m_out = 4'h0;
   logic [7:0] m_shadow = 8'h00;

   always #2 clk = ~clk;

   gpio_setclr_reg u_gpio_setclr_reg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_addr(cfg_addr), .cfg_be_n(cfg_be_n), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .dir(dir), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input string tag);
      exp_t e;
      e.out = m_out; e.oe = dir; e.rd = {16'h0, m_shadow, 8'h0}; e.tag = tag;
      sb.push_back(e);
   endtask

   // Driver: one write, model update, readback expectation queued
   task automatic wr(input logic [7:0] a, input logic [3:0] ben,
                     input logic [31:0] d, input string tag);
      @(negedge clk); #0.5;
      cfg_rd = 1'b0; cfg_wr = 1'b1; cfg_addr = a; cfg_be_n = ben; cfg_wdata = d;
      #0.5;
      check(gpio_out == m_out, {"R5 ", tag}, {28'h0, gpio_out}, {28'h0, m_out});
      if (a[7:2] == 6'h19 && !ben[1]) begin
         for (int i = 0; i < 4; i++) begin
            if (d[12+i])     m_out[i] = 1'b1;
            else if (d[8+i]) m_out[i] = 1'b0;
         end
         m_shadow = d[15:8];
      end
      @(posedge clk); #0.5;
      cfg_wr = 1'b0; cfg_rd = 1'b1; cfg_addr = 8'h64; cfg_be_n = 4'hF; cfg_wdata = '0;
      push(tag);
   endtask

   task automatic set_dir(input logic [3:0] v, input string tag);
      @(negedge clk); #0.5;
      dir = v; cfg_rd = 1'b1; cfg_addr = 8'h64;
      push(tag);
   endtask

   // Monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(gpio_out == e.out, {e.tag, " out"}, {28'h0, gpio_out}, {28'h0, e.out});
         check(gpio_oe == e.oe, {e.tag, " oe R6"}, {28'h0, gpio_oe}, {28'h0, e.oe});
         check(cfg_rdata == e.rd, {e.tag, " rdata R8"}, cfg_rdata, e.rd);
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5;
      // R9 reset state
      check(gpio_out == 4'h0, "R9 reset out", {28'h0, gpio_out}, 32'h0);
      rst_n = 1'b1;
      set_dir(4'h0, "R9 after reset");
      set_dir(4'hF, "R6 all bidirectional");
      wr(8'h64, 4'b1101, 32'h0000_5000, "R3 set 0101");
      wr(8'h64, 4'b1101, 32'h0000_0100, "R2 clear pin0");
      wr(8'h66, 4'b1101, 32'h0000_0000, "R4 zero write");
      wr(8'h60, 4'b1101, 32'h0000_F000, "R1 wrong address");
      wr(8'h64, 4'b0010, 32'hFFFF_FFFF, "R1 lane disabled");
      wr(8'h64, 4'b1101, 32'h0000_2200, "R10 set wins");
      wr(8'h64, 4'b0000, 32'hABCD_F0EF, "R3 all lanes set all");
      wr(8'h64, 4'b1101, 32'h0000_0F00, "R2 clear all");
      set_dir(4'b0011, "R6 upper input-only");
      wr(8'h64, 4'b1101, 32'h0000_C000, "R7 set undriven pins");
      wr(8'h64, 4'b1101, 32'h0000_4100, "R7 mixed undriven");
      set_dir(4'hF, "R7 release drives kept data");
      // R8 no read, no data
      @(negedge clk); #0.5;
      cfg_rd = 1'b0;
      #0.5;
      check(cfg_rdata == 32'h0, "R8 rd low", cfg_rdata, 32'h0);
      // R9 reset mid-run
      rst_n = 1'b0; #0.5;
      check(gpio_out == 4'h0, "R9 async reset out", {28'h0, gpio_out}, 32'h0);
      m_out = 4'h0; m_shadow = 8'h00;
      @(posedge clk); #0.5;
      rst_n = 1'b1;
      set_dir(4'hF, "R9 readback after reset");
      repeat (3) @(posedge clk);
      check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule